// File: doc/BRIEF.md
# Real-Mode Exception Dispatch Unit

This unit works beside a small 16-bit instruction sequencer. At each instruction boundary it decides which interrupt or exception, if any, the sequencer must enter next. The sequencer reports the boundary with a strobe. At the same time it presents the fault conditions found while the instruction ran, any software interrupt request (breakpoint, INTO, INT n), the trap flag, and both the current and the next instruction offsets. An external NMI pin is watched for rising edges. A rising edge stays pending until a boundary can accept it.

One clock after the boundary the unit raises a single-cycle take strobe. With it come the chosen vector number, the byte address of that vector's table entry, the offset the stack sequence must push as the return point, and a command to clear the trap flag. Faults and NMI return to the start of the instruction they interrupted. Traps and software interrupts return to the next instruction.

Top module: `exc_dispatch`

## Requirements
- R1: While reset is held, and after it is released with no boundary seen, `take` and `tf_clr` are 0 and `vec`, `tbl_addr` and `ret_ip` are 0.
- R2: Results appear on the clock edge after the edge that samples `boundary` high, and `take` is high for exactly that one cycle. With no boundary, `take` stays 0.
- R3: Instruction faults map to fixed vectors: divide 0, bound 5, undefined opcode 6, coprocessor absent 7, table limit 8, coprocessor overrun 9, top-offset word access 13. When several faults are present, the lowest vector wins. A fault returns to `cur_ip`.
- R4: The top-offset fault (vector 13) is raised when `mem_word` is 1 and `mem_off` is 16'hFFFF. A byte access at that offset, or a word access at any other offset, raises nothing.
- R5: Software requests return to `nxt_ip`. Breakpoint gives vector 3. INTO with `ovf_flag` set gives vector 4. INTO with `ovf_flag` clear gives nothing. INT n gives `swint_num`. When more than one is present, breakpoint wins over INTO, and INTO wins over INT n.
- R6: A rising edge on `nmi_pin` becomes pending and gives vector 2, returning to `cur_ip`. Each edge is taken once. Holding the pin high does not raise it again.
- R7: With `tf_in` high at a boundary and nothing else pending, vector 1 is taken, returning to `nxt_ip`.
- R8: The groups rank faults first, then software requests, then NMI, then single-step. An NMI that loses stays pending for a later boundary.
- R9: `tbl_addr` equals `vec` times 4, and `tf_clr` is high whenever `take` is high.
- R10: Vectors 10–12, 14, 15 and 17–31 are produced only when they are passed through from INT n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary strobe |
| flt_div | input | 1 | Divide error in this instruction |
| flt_bound | input | 1 | Bound range exceeded |
| flt_undef | input | 1 | Undefined opcode |
| flt_nocop | input | 1 | Coprocessor instruction with no coprocessor |
| flt_tbl | input | 1 | Descriptor table limit too small |
| flt_copseg | input | 1 | Coprocessor operand overran segment |
| mem_word | input | 1 | Instruction made a word-sized memory access |
| mem_off | input | 16 | Offset of that memory access |
| bkpt_req | input | 1 | Breakpoint instruction executed |
| into_req | input | 1 | INTO executed |
| ovf_flag | input | 1 | Overflow flag at INTO |
| swint_req | input | 1 | INT n executed |
| swint_num | input | 8 | Vector number n of INT n |
| nmi_pin | input | 1 | External non-maskable interrupt pin |
| tf_in | input | 1 | Trap flag during the completed instruction |
| cur_ip | input | 16 | Offset of the completed instruction's first byte |
| nxt_ip | input | 16 | Offset of the following instruction |
| take | output | 1 | One-cycle strobe: enter the vector |
| vec | output | 8 | Selected vector number |
| tbl_addr | output | 10 | Byte address of the vector-table entry |
| ret_ip | output | 16 | Return offset to push |
| tf_clr | output | 1 | Clear the trap flag |

## Verification
All four results (`take`, `vec`, `tbl_addr`, `ret_ip`) and `tf_clr` change on the single register stage after the edge that samples `boundary`. The bench drives its stimulus on a falling edge and holds `boundary` across one rising edge. It then checks every result on the next falling edge and checks on the falling edge after that that `take` has dropped. An NMI edge is pending state, not a one-cycle result, so the bench keeps its own model of the pending bit across boundaries. A deferred NMI is therefore expected at whichever later boundary first has no fault or software request.

// File: rtl/exc_dispatch.sv
module exc_dispatch #(
  parameter int IP_W  = 16,
  parameter int VEC_W = 8,
  localparam int TBL_W = VEC_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             flt_div,
  input  logic             flt_bound,
  input  logic             flt_undef,
  input  logic             flt_nocop,
  input  logic             flt_tbl,
  input  logic             flt_copseg,
  input  logic             mem_word,
  input  logic [IP_W-1:0]  mem_off,
  input  logic             bkpt_req,
  input  logic             into_req,
  input  logic             ovf_flag,
  input  logic             swint_req,
  input  logic [VEC_W-1:0] swint_num,
  input  logic             nmi_pin,
  input  logic             tf_in,
  input  logic [IP_W-1:0]  cur_ip,
  input  logic [IP_W-1:0]  nxt_ip,
  output logic             take,
  output logic [VEC_W-1:0] vec,
  output logic [TBL_W-1:0] tbl_addr,
  output logic [IP_W-1:0]  ret_ip,
  output logic             tf_clr
);

  typedef enum logic [2:0] {G_NONE, G_FLT, G_SW, G_NMI, G_STEP} grp_e;

  logic             wrap_flt, flt_any, sw_any, nmi_edge, nmi_any;
  logic             nmi_q, nmi_pend;
  logic [VEC_W-1:0] flt_vec, sw_vec, nxt_vec;
  grp_e             grp;

  assign wrap_flt = mem_word && (mem_off == {IP_W{1'b1}});
  assign flt_any  = flt_div | flt_bound | flt_undef | flt_nocop | flt_tbl | flt_copseg | wrap_flt;
  assign sw_any   = bkpt_req | (into_req & ovf_flag) | swint_req;
  assign nmi_edge = nmi_pin & ~nmi_q;
  assign nmi_any  = nmi_pend | nmi_edge;

  always_comb begin
    if      (flt_div)    flt_vec = VEC_W'(0);
    else if (flt_bound)  flt_vec = VEC_W'(5);
    else if (flt_undef)  flt_vec = VEC_W'(6);
    else if (flt_nocop)  flt_vec = VEC_W'(7);
    else if (flt_tbl)    flt_vec = VEC_W'(8);
    else if (flt_copseg) flt_vec = VEC_W'(9);
    else                 flt_vec = VEC_W'(13);
  end

  always_comb begin
    if      (bkpt_req)             sw_vec = VEC_W'(3);
    else if (into_req && ovf_flag) sw_vec = VEC_W'(4);
    else                           sw_vec = swint_num;
  end

  always_comb begin
    if      (flt_any) grp = G_FLT;
    else if (sw_any)  grp = G_SW;
    else if (nmi_any) grp = G_NMI;
    else if (tf_in)   grp = G_STEP;
    else              grp = G_NONE;
  end

  always_comb begin
    unique case (grp)
      G_FLT:   nxt_vec = flt_vec;
      G_SW:    nxt_vec = sw_vec;
      G_NMI:   nxt_vec = VEC_W'(2);
      G_STEP:  nxt_vec = VEC_W'(1);
      default: nxt_vec = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take     <= 1'b0;
      vec      <= '0;
      ret_ip   <= '0;
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_pin;
      nmi_pend <= nmi_any & ~(boundary && grp == G_NMI);
      take     <= boundary && grp != G_NONE;
      if (boundary && grp != G_NONE) begin
        vec    <= nxt_vec;
        ret_ip <= (grp == G_FLT || grp == G_NMI) ? cur_ip : nxt_ip;
      end
    end
  end

  assign tbl_addr = {vec, 2'b00};
  assign tf_clr   = take;

  p_no_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(boundary) |-> !take);

  p_fault_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(boundary && flt_any) |-> take && ret_ip == $past(cur_ip));

  p_nmi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(boundary && nmi_any && !flt_any && !sw_any)
      |-> take && vec == VEC_W'(2) && ret_ip == $past(cur_ip));

  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(boundary && tf_in && !flt_any && !sw_any && !nmi_any)
      |-> take && vec == VEC_W'(1) && ret_ip == $past(nxt_ip));

  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ((vec >= 10 && vec <= 12) || vec == 14 || vec == 15 || (vec >= 17 && vec <= 31)))
      |-> $past(swint_req));

endmodule

// File: tb/exc_dispatch_tb_top.sv
module exc_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, boundary = 1'b0;
  logic flt_div = 0, flt_bound = 0, flt_undef = 0, flt_nocop = 0, flt_tbl = 0, flt_copseg = 0;
  logic mem_word = 0; logic [15:0] mem_off = '0;
  logic bkpt_req = 0, into_req = 0, ovf_flag = 0, swint_req = 0; logic [7:0] swint_num = '0;
  logic nmi_pin = 0, tf_in = 0;
  logic [15:0] cur_ip = '0, nxt_ip = '0;
  logic take, tf_clr; logic [7:0] vec; logic [9:0] tbl_addr; logic [15:0] ret_ip;

  int checks = 0, errors = 0;
  logic pend_m = 1'b0;
  logic nmi_prev = 1'b0;

  exc_dispatch dut_i (.clk, .rst_n, .boundary, .flt_div, .flt_bound, .flt_undef, .flt_nocop,
    .flt_tbl, .flt_copseg, .mem_word, .mem_off, .bkpt_req, .into_req, .ovf_flag, .swint_req,
    .swint_num, .nmi_pin, .tf_in, .cur_ip, .nxt_ip, .take, .vec, .tbl_addr, .ret_ip, .tf_clr);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_req();
    {flt_div, flt_bound, flt_undef, flt_nocop, flt_tbl, flt_copseg} = '0;
    mem_word = 0; mem_off = 16'h1234;
    bkpt_req = 0; into_req = 0; ovf_flag = 0; swint_req = 0; swint_num = '0; tf_in = 0;
  endtask

  // Called at a falling edge with requests already driven; runs the boundary and checks.
  task automatic run_boundary(input string req);
    logic [6:0] f; int ev; bit tk; bit edge_m; logic [15:0] er;
    f = {mem_word && mem_off == 16'hFFFF, flt_copseg, flt_tbl, flt_nocop, flt_undef, flt_bound, flt_div};
    edge_m = nmi_pin && !nmi_prev;
    tk = 1; ev = 0; er = cur_ip;
    if (f != 0) begin
      if (f[0]) ev = 0; else if (f[1]) ev = 5; else if (f[2]) ev = 6; else if (f[3]) ev = 7;
      else if (f[4]) ev = 8; else if (f[5]) ev = 9; else ev = 13;
    end else if (bkpt_req) begin ev = 3; er = nxt_ip; end
    else if (into_req && ovf_flag) begin ev = 4; er = nxt_ip; end
    else if (swint_req) begin ev = swint_num; er = nxt_ip; end
    else if (pend_m || edge_m) begin ev = 2; end
    else if (tf_in) begin ev = 1; er = nxt_ip; end
    else tk = 0;
    pend_m = (pend_m | edge_m) & !(tk && ev == 2 && f == 0 && !bkpt_req && !(into_req && ovf_flag) && !swint_req);
    boundary = 1;
    @(negedge clk);
    nmi_prev = nmi_pin;
    boundary = 0;
    chk(take == tk, {req, " R2 take"}, take, tk);
    if (tk) begin
      chk(vec == ev[7:0], {req, " vec"}, vec, ev);
      chk(ret_ip == er, {req, " ret_ip"}, ret_ip, er);
      chk(tbl_addr == 10'(ev * 4) && tf_clr, {req, " R9 tbl_addr/tf_clr"}, tbl_addr, ev * 4);
    end
    clear_req();
    @(negedge clk);
    nmi_prev = nmi_pin;
    chk(!take && !tf_clr, "R2 one-cycle take", take, 0);
  endtask

  initial begin
    clear_req();
    repeat (3) @(negedge clk);
    chk(!take && !tf_clr && vec == 0 && tbl_addr == 0 && ret_ip == 0, "R1 reset state", vec, 0);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    chk(!take && vec == 0 && ret_ip == 0, "R1 after reset", take, 0);

    // Sweep: 7 fault bits x 4 software kinds x trap flag x NMI edge (R3 R5 R6 R7 R8 R10)
    for (int m = 0; m < 128; m++)
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 2; t++)
          for (int n = 0; n < 2; n++) begin
            {flt_div, flt_bound, flt_undef, flt_nocop, flt_tbl, flt_copseg} = m[5:0];
            mem_word = 1; mem_off = m[6] ? 16'hFFFF : 16'hFFFE;
            bkpt_req = (s == 1); into_req = (s == 2); ovf_flag = (s == 2); swint_req = (s == 3);
            swint_num = 8'(32 + (m * 7 + s) % 224);
            tf_in = t[0]; nmi_pin = n[0];
            cur_ip = 16'(m * 331 + s * 17 + t * 5 + n);
            nxt_ip = cur_ip + 16'(1 + (m % 5));
            run_boundary("R3/R5/R6/R7/R8 sweep");
            nmi_pin = 0;
            @(negedge clk); nmi_prev = nmi_pin;
          end

    // R4: byte access at top offset and word access elsewhere raise nothing
    mem_word = 0; mem_off = 16'hFFFF; cur_ip = 16'h0100; nxt_ip = 16'h0102;
    run_boundary("R4 byte at FFFF");
    mem_word = 1; mem_off = 16'h7FFF; run_boundary("R4 word at 7FFF");
    mem_word = 1; mem_off = 16'hFFFF; run_boundary("R4 word at FFFF");
    chk(1, "R4 directed done", 0, 0);

    // R5: INTO without overflow does nothing; INT n passes any number, even reserved
    into_req = 1; ovf_flag = 0; run_boundary("R5 INTO no overflow");
    for (int k = 0; k < 256; k += 17) begin
      swint_req = 1; swint_num = 8'(k); cur_ip = 16'(k); nxt_ip = 16'(k + 2);
      run_boundary("R10 INT n pass-through");
    end
    bkpt_req = 1; into_req = 1; ovf_flag = 1; swint_req = 1; swint_num = 8'd99;
    run_boundary("R5 software ranking");

    // R6: held NMI level fires once
    nmi_pin = 1; cur_ip = 16'h2000; nxt_ip = 16'h2003; run_boundary("R6 NMI edge");
    nmi_pin = 1; run_boundary("R6 NMI held no retrigger");
    nmi_pin = 0; @(negedge clk); nmi_prev = 0;

    // R8: NMI deferred behind a fault, then taken
    nmi_pin = 1; flt_undef = 1; run_boundary("R8 fault beats NMI");
    tf_in = 1; cur_ip = 16'h3000; nxt_ip = 16'h3001; run_boundary("R8 deferred NMI beats step");
    tf_in = 1; run_boundary("R7 step after NMI");
    nmi_pin = 0; @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule